// File: doc/BRIEF.md
# Multi-Register Byte Table Lookup

This block looks up sixteen bytes at a time in a table built from up to four 128-bit registers. The caller supplies the table registers, a two-bit length code that says how many of them are in use (16, 32, 48 or 64 bytes), a 16-byte index vector, the prior destination vector and a one-bit policy for out-of-range indices. Each output byte takes the table byte its index names. When the index is out of range, the output byte is either zero or a copy of the matching destination byte, as the policy selects.

The operands arrive on a valid/ready input channel and the result leaves on a valid/ready output channel through a single output register. The input is accepted whenever the output register is empty or is being drained in the same cycle, so `in_ready = !out_valid || out_ready`. While the consumer holds `out_ready` low, a pending result stays in place and unchanged, and no new beat is taken in.

Top module: `byte_table_lookup`

## Requirements
- R1: After reset, and until the first accepted beat, `out_valid` is 0.
- R2: Table byte k is bits [8k+7:8k] of `tbl_data`. Register 0 holds bytes 0..15, register 1 holds bytes 16..31, and so on. For every output byte i whose index byte (bits [8i+7:8i] of `idx_vec`) is below the table length, output byte i equals table byte index.
- R3: `tbl_len` value n selects a table of (n+1)*16 bytes. An index of (n+1)*16-1 is in range and an index of (n+1)*16 is out of range.
- R4: When `keep_oob` is 0, every out-of-range index gives output byte 0x00.
- R5: When `keep_oob` is 1, every out-of-range index gives output byte i equal to byte i of `dst_vec`.
- R6: Index bytes are unsigned, so values 64..255 are out of range for every length code.
- R7: Each output byte depends only on its own index byte, its own destination byte, the table, the length code and the policy. Mixed in-range and out-of-range indices in one vector are each resolved on their own.
- R8: A beat accepted at a clock edge (`in_valid && in_ready`) has its result on `out_data`, with `out_valid` high, right after that same edge.
- R9: `in_ready` equals `!out_valid || out_ready`. While `out_valid && !out_ready`, both `out_valid` and `out_data` are held at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| in_valid | input | 1 | Operand beat offered |
| in_ready | output | 1 | Operand beat can be taken this cycle |
| tbl_data | input | 512 | Four table registers; register r sits at bits [128r+127:128r] |
| tbl_len | input | 2 | Table length code, n gives (n+1)*16 bytes |
| idx_vec | input | 128 | Sixteen unsigned index bytes |
| dst_vec | input | 128 | Prior destination bytes |
| keep_oob | input | 1 | 0: out-of-range gives zero; 1: out-of-range keeps destination byte |
| out_valid | output | 1 | Result held in output register |
| out_ready | input | 1 | Consumer takes the result this cycle |
| out_data | output | 128 | Looked-up result vector |

## Verification
The lookup result is due exactly one edge after the beat is accepted, and `in_ready` is due in the same cycle, since it is combinational from `out_valid` and `out_ready`. The bench drives operands after the falling edge and works out, from the state it has predicted, whether the coming rising edge accepts the beat. It then predicts the result register for that edge and compares `out_valid`, `out_data` and `in_ready` at the next falling edge. In stall cycles the prediction keeps the previous result, so a held result is checked once for every cycle it stays stalled.

// File: rtl/tbl_pkg.sv
package tbl_pkg;
  localparam int BYTE_W = 8;
  localparam int IDX_W  = 8;

  typedef enum logic {
    OOB_ZERO = 1'b0,
    OOB_KEEP = 1'b1
  } oob_mode_e;
endpackage

// File: rtl/tbl_byte_sel.sv
module tbl_byte_sel
  import tbl_pkg::*;
#(
  parameter int LANES    = 16,
  parameter int MAX_REGS = 4
) (
  input  logic [LANES*MAX_REGS*BYTE_W-1:0] tbl_flat,
  input  logic [$clog2(MAX_REGS)-1:0]      len_code,
  input  logic [IDX_W-1:0]                 idx,
  input  logic [BYTE_W-1:0]                dst_byte,
  input  oob_mode_e                        mode,
  output logic [BYTE_W-1:0]                res
);
  localparam int TBL_BYTES = LANES * MAX_REGS;
  localparam int AW        = $clog2(TBL_BYTES);
  localparam int CW        = IDX_W + 1;

  logic [BYTE_W-1:0] tbl_b [TBL_BYTES];
  logic [CW-1:0]     limit;
  logic              in_range;
  logic [BYTE_W-1:0] picked;

  for (genvar k = 0; k < TBL_BYTES; k++) begin : g_split
    assign tbl_b[k] = tbl_flat[k*BYTE_W +: BYTE_W];
  end

  always_comb begin
    limit    = (CW'(len_code) + CW'(1)) * CW'(LANES);
    in_range = {1'b0, idx} < limit;
    picked   = tbl_b[idx[AW-1:0]];
    if (in_range)              res = picked;
    else if (mode == OOB_KEEP) res = dst_byte;
    else                       res = '0;
  end
endmodule

// File: rtl/tbl_out_reg.sv
module tbl_out_reg #(
  parameter int W = 128
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic         drain,
  input  logic [W-1:0] d,
  output logic         q_valid,
  output logic [W-1:0] q
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      q_valid <= 1'b0;
      q       <= '0;
    end else if (load) begin
      q_valid <= 1'b1;
      q       <= d;
    end else if (drain) begin
      q_valid <= 1'b0;
    end
  end
endmodule

// File: rtl/byte_table_lookup.sv
module byte_table_lookup
  import tbl_pkg::*;
#(
  parameter int LANES    = 16,
  parameter int MAX_REGS = 4
) (
  input  logic                              clk,
  input  logic                              rst_n,
  input  logic                              in_valid,
  output logic                              in_ready,
  input  logic [LANES*MAX_REGS*BYTE_W-1:0]  tbl_data,
  input  logic [$clog2(MAX_REGS)-1:0]       tbl_len,
  input  logic [LANES*IDX_W-1:0]            idx_vec,
  input  logic [LANES*BYTE_W-1:0]           dst_vec,
  input  logic                              keep_oob,
  output logic                              out_valid,
  input  logic                              out_ready,
  output logic [LANES*BYTE_W-1:0]           out_data
);
  localparam int VW = LANES * BYTE_W;

  logic [VW-1:0] lookup;
  logic          accept;
  oob_mode_e     mode;

  assign mode     = oob_mode_e'(keep_oob);
  assign in_ready = !out_valid || out_ready;
  assign accept   = in_valid && in_ready;

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    tbl_byte_sel #(.LANES(LANES), .MAX_REGS(MAX_REGS)) u_sel (
      .tbl_flat (tbl_data),
      .len_code (tbl_len),
      .idx      (idx_vec[i*IDX_W +: IDX_W]),
      .dst_byte (dst_vec[i*BYTE_W +: BYTE_W]),
      .mode     (mode),
      .res      (lookup[i*BYTE_W +: BYTE_W])
    );
  end

  tbl_out_reg #(.W(VW)) u_out (
    .clk     (clk),
    .rst_n   (rst_n),
    .load    (accept),
    .drain   (out_ready),
    .d       (lookup),
    .q_valid (out_valid),
    .q       (out_data)
  );
endmodule

// File: rtl/byte_table_lookup_chk.sv
module byte_table_lookup_chk #(
  parameter int VW = 128
) (
  input logic          clk,
  input logic          rst_n,
  input logic          in_valid,
  input logic          in_ready,
  input logic [7:0]    idx0,
  input logic [7:0]    dst0,
  input logic          keep_oob,
  input logic          out_valid,
  input logic          out_ready,
  input logic [VW-1:0] out_data
);
  assert_ready_rule_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid |-> in_ready);

  assert_hold_stall_R9: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data));

  assert_one_cycle_R8: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready |=> out_valid);

  assert_no_spurious_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !out_valid && !in_valid |=> !out_valid);

  assert_zero_oob_R4: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && !keep_oob && idx0[7:6] != 2'b00 |=> out_data[7:0] == 8'h00);

  assert_keep_oob_R5: assert property (@(posedge clk) disable iff (!rst_n)
    in_valid && in_ready && keep_oob && idx0[7:6] != 2'b00 |=> out_data[7:0] == $past(dst0));
endmodule

bind byte_table_lookup byte_table_lookup_chk #(.VW(LANES*8)) u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .in_valid  (in_valid),
  .in_ready  (in_ready),
  .idx0      (idx_vec[7:0]),
  .dst0      (dst_vec[7:0]),
  .keep_oob  (keep_oob),
  .out_valid (out_valid),
  .out_ready (out_ready),
  .out_data  (out_data)
);

// File: tb/sim_byte_table_lookup.sv
`timescale 1ns/1ps
module sim_byte_table_lookup;
  logic         clk = 1'b0;
  logic         rst_n = 1'b0;
  logic         in_valid = 1'b0;
  logic         in_ready;
  logic [511:0] tbl_data = '0;
  logic [1:0]   tbl_len = '0;
  logic [127:0] idx_vec = '0;
  logic [127:0] dst_vec = '0;
  logic         keep_oob = 1'b0;
  logic         out_valid;
  logic         out_ready = 1'b0;
  logic [127:0] out_data;

  int errors = 0;
  int checks = 0;
  bit done = 0;

  logic         exp_valid = 1'b0;
  logic [127:0] exp_data = '0;

  always #2 clk = ~clk;

  byte_table_lookup u0 (
    .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ready(in_ready),
    .tbl_data(tbl_data), .tbl_len(tbl_len), .idx_vec(idx_vec), .dst_vec(dst_vec),
    .keep_oob(keep_oob), .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data)
  );

  function automatic logic [127:0] ref_lookup(logic [511:0] t, logic [1:0] n,
                                              logic [127:0] ix, logic [127:0] d, logic k);
    logic [127:0] r;
    int lim;
    lim = (int'(n) + 1) * 16;
    for (int i = 0; i < 16; i++) begin
      int v;
      v = int'(ix[i*8 +: 8]);
      if (v < lim)  r[i*8 +: 8] = t[v*8 +: 8];
      else if (k)   r[i*8 +: 8] = d[i*8 +: 8];
      else          r[i*8 +: 8] = 8'h00;
    end
    return r;
  endfunction

  function automatic logic [511:0] rand_tbl();
    logic [511:0] t;
    for (int w = 0; w < 16; w++) t[w*32 +: 32] = $urandom;
    return t;
  endfunction

  function automatic logic [127:0] rand_vec();
    return {$urandom, $urandom, $urandom, $urandom};
  endfunction

  task automatic check(string tag, logic [127:0] act, logic [127:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // Drive one cycle of stimulus (after negedge), predict the coming edge,
  // then compare at the following negedge.
  task automatic step(string tag, logic iv, logic ordy);
    logic rdy_exp;
    in_valid  = iv;
    out_ready = ordy;
    rdy_exp   = !exp_valid || ordy;
    #0.5;
    check({tag, " R9 in_ready"}, {127'b0, in_ready}, {127'b0, rdy_exp});
    if (iv && rdy_exp) begin
      exp_valid = 1'b1;
      exp_data  = ref_lookup(tbl_data, tbl_len, idx_vec, dst_vec, keep_oob);
    end else if (ordy) begin
      exp_valid = 1'b0;
    end
    @(negedge clk);
    check({tag, " R8 out_valid"}, {127'b0, out_valid}, {127'b0, exp_valid});
    if (exp_valid) check({tag, " data"}, out_data, exp_data);
  endtask

  task automatic send(string tag, logic [511:0] t, logic [1:0] n,
                      logic [127:0] ix, logic [127:0] d, logic k);
    tbl_data = t; tbl_len = n; idx_vec = ix; dst_vec = d; keep_oob = k;
    step(tag, 1'b1, 1'b1);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    logic [511:0] t;
    logic [127:0] ix;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1: reset state
    check("R1 reset out_valid", {127'b0, out_valid}, 128'b0);
    step("R1 idle", 1'b0, 1'b0);

    // R2: identity and reversed indices over a full table
    t = rand_tbl();
    for (int i = 0; i < 16; i++) ix[i*8 +: 8] = 8'(i);
    send("R2 identity low", t, 2'd3, ix, rand_vec(), 1'b0);
    for (int i = 0; i < 16; i++) ix[i*8 +: 8] = 8'(63 - i);
    send("R2 reversed high", t, 2'd3, ix, rand_vec(), 1'b0);

    // R3: boundaries for each length code, both policies
    for (int n = 0; n < 4; n++) begin
      for (int i = 0; i < 16; i++) ix[i*8 +: 8] = 8'((n + 1) * 16 - 1 + (i % 2));
      send("R3 boundary zero", rand_tbl(), 2'(n), ix, rand_vec(), 1'b0);
      send("R3 boundary keep", rand_tbl(), 2'(n), ix, rand_vec(), 1'b1);
    end

    // R4 / R5: all indices out of range for a one-register table
    for (int i = 0; i < 16; i++) ix[i*8 +: 8] = 8'(16 + i * 3);
    send("R4 zero policy", rand_tbl(), 2'd0, ix, rand_vec(), 1'b0);
    send("R5 keep policy", rand_tbl(), 2'd0, ix, rand_vec(), 1'b1);

    // R6: large unsigned indices
    for (int i = 0; i < 16; i++) ix[i*8 +: 8] = 8'(64 + i * 12);
    send("R6 high idx zero", rand_tbl(), 2'd3, ix, rand_vec(), 1'b0);
    send("R6 high idx keep", rand_tbl(), 2'd3, ix, rand_vec(), 1'b1);

    // R7: random mixes, all lanes resolved separately
    for (int r = 0; r < 200; r++) begin
      for (int i = 0; i < 16; i++) ix[i*8 +: 8] = ($urandom % 2) ? 8'($urandom % 80) : 8'($urandom);
      send("R7 mixed", rand_tbl(), 2'($urandom), ix, rand_vec(), 1'($urandom));
    end

    // R9: random back-pressure and gaps
    for (int r = 0; r < 400; r++) begin
      tbl_data = rand_tbl(); tbl_len = 2'($urandom); idx_vec = rand_vec();
      dst_vec = rand_vec(); keep_oob = 1'($urandom);
      step("R9 backpressure", 1'($urandom), 1'($urandom));
    end
    step("R9 drain", 1'b0, 1'b1);

    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule